// File: doc/BRIEF.md
# Paired Interprocessor Link Interface

This block models two matched 16-bit I/O interface cards that let one minicomputer exchange words with another. Each card sits on its own I/O instruction port and decodes eight instruction kinds: set and clear control, set flag, skip on flag clear or flag set, write the output register, and load or merge from the input register. Each card holds its own command, control, flag and flag-buffer flip-flops, together with an input register and an output register.

A set-control instruction arms the card and also launches the output word. In link mode the word is sent as bytes, most significant byte first, over a byte-wide full-duplex channel with a valid/ready handshake in each direction. The receiving side reassembles incoming bytes into a word, writes it to the input register, clears command and raises the flag. In diagnostic mode the two cards are cross-wired. A set-control copies the output register straight into the partner card's input register and sets the partner's flag. In this mode the byte channel is not used.

One mode input selects link or diagnostic operation for both cards at once. Interrupt priority chaining and bootstrap loading are not part of the block.

Top module: `ipl_pair`

## Requirements
- R1: Reset clears command and control, sets flag and flag buffer, zeroes the input and output registers, leaves the transmitter idle and discards any partly received word. After reset, a load returns 0, and a single received byte raises no flag.
- R2: Instruction codes on `io_op` are 0 set-control, 1 clear-control, 2 set-flag, 3 skip-if-flag-clear, 4 skip-if-flag-set, 5 output, 6 load and 7 merge. Set-control sets command and control on the next clock edge. Clear-control clears both.
- R3: Set-flag sets the flag. An instruction whose hold/clear bit `io_hc` is 1 leaves the flag clear after it executes, and this includes set-flag.
- R4: In the same cycle as the instruction, `io_skip` is 1 for skip-if-flag-clear while the flag is 0, and for skip-if-flag-set while the flag is 1. Otherwise it is 0. For every instruction except load and merge, `io_rdata` equals `io_wdata`.
- R5: Output stores `io_wdata` in the output register. Load returns the input register on `io_rdata`. Merge returns `io_wdata` OR the input register.
- R6: In link mode, a set-control on an idle transmitter presents the upper byte of the output register on `tx_data` with `tx_valid` high from the next cycle on. Each byte is held until `tx_ready` is seen. The lower byte follows, and `tx_valid` then drops.
- R7: A set-control that arrives before both bytes of the previous word have been accepted sends nothing: only the bytes of the earlier word appear.
- R8: In diagnostic mode, a set-control on one card writes its output register into the partner card's input register and sets the partner's flag on the next edge. Nothing appears on the byte channel.
- R9: A first received byte is held without raising the flag. The next byte completes the word as {held byte, new byte}. The word is written to the input register, command is cleared and the flag is set on the edge that accepts that byte.
- R10: When a word completes in the same cycle as an instruction on that card that would clear the flag or set command, the completion wins: the flag ends set and command ends clear.
- R11: `rx_ready` is 1 for both cards in link mode and 0 in diagnostic mode. Bytes offered in diagnostic mode are neither accepted nor held.
- R12: The mode input acts on both cards together. Diagnostic transfers work in both directions, and so do link transfers between the two cards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| diag_mode | input | 1 | 1 = cards cross-wired (diagnostic), 0 = byte link |
| io_strobe | input | 2 | Per card: instruction present this cycle |
| io_op | input | 2x3 | Per card: instruction code (see R2) |
| io_hc | input | 2 | Per card: hold/clear bit, clears flag after the instruction |
| io_wdata | input | 2x16 | Per card: bus data into the card |
| io_rdata | output | 2x16 | Per card: bus data returned, combinational |
| io_skip | output | 2 | Per card: skip request, combinational |
| cmd_o | output | 2 | Per card: command flip-flop |
| ctl_o | output | 2 | Per card: control flip-flop |
| flag_o | output | 2 | Per card: flag flip-flop |
| flagbuf_o | output | 2 | Per card: flag-buffer flip-flop |
| tx_valid | output | 2 | Per card: outgoing byte valid |
| tx_data | output | 2x8 | Per card: outgoing byte |
| tx_ready | input | 2 | Per card: far end takes the outgoing byte |
| rx_valid | input | 2 | Per card: incoming byte valid |
| rx_data | input | 2x8 | Per card: incoming byte |
| rx_ready | output | 2 | Per card: card takes the incoming byte |

## Verification
A card can see the last byte of an incoming word complete on the same edge as one of its own instructions that carries the hold/clear bit. Set-control is the sharpest such instruction, because it also tries to set command. The bench provokes this by driving the final byte on `rx_valid` and a set-control with `io_hc` high in the same cycle. It judges the result after that edge by the flag reading 1, command 0 and control 1, and then by a load that returns the completed word.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

    // Instruction codes decoded by each card (fixed encoding, see R2)
    typedef enum logic [2:0] {
        OP_STC   = 3'd0,
        OP_CLC   = 3'd1,
        OP_STF   = 3'd2,
        OP_SFC   = 3'd3,
        OP_SFS   = 3'd4,
        OP_OUT   = 3'd5,
        OP_LOAD  = 3'd6,
        OP_MERGE = 3'd7
    } io_op_e;

endpackage

// File: rtl/ipl_card_ctrl.sv
module ipl_card_ctrl
    import ipl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  io_op_e            op,
    input  logic              hc,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              skip,
    input  logic              word_in_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              cmd,
    output logic              ctl,
    output logic              flg,
    output logic              fbf,
    output logic [WORD_W-1:0] obuf,
    output logic              stc_fire
);

    typedef struct packed {
        logic              cmd;
        logic              ctl;
        logic              flg;
        logic              fbf;
        logic [WORD_W-1:0] ibuf;
        logic [WORD_W-1:0] obuf;
    } card_st_t;

    card_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = wdata;
        skip  = 1'b0;
        if (strobe) begin
            case (op)
                OP_STC:   begin st_d.cmd = 1'b1; st_d.ctl = 1'b1; end
                OP_CLC:   begin st_d.cmd = 1'b0; st_d.ctl = 1'b0; end
                OP_STF:   begin st_d.flg = 1'b1; st_d.fbf = 1'b1; end
                OP_SFC:   skip = ~st_q.flg;
                OP_SFS:   skip = st_q.flg;
                OP_OUT:   st_d.obuf = wdata;
                OP_LOAD:  rdata = st_q.ibuf;
                OP_MERGE: rdata = wdata | st_q.ibuf;
                default:  ;
            endcase
            if (hc) begin
                st_d.flg = 1'b0;
                st_d.fbf = 1'b0;
            end
        end
        // An arriving word overrides the instruction's flag/command effects
        if (word_in_valid) begin
            st_d.ibuf = word_in;
            st_d.cmd  = 1'b0;
            st_d.flg  = 1'b1;
            st_d.fbf  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: 1'b0, ctl: 1'b0, flg: 1'b1, fbf: 1'b1,
                      ibuf: '0, obuf: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd      = st_q.cmd;
    assign ctl      = st_q.ctl;
    assign flg      = st_q.flg;
    assign fbf      = st_q.fbf;
    assign obuf     = st_q.obuf;
    assign stc_fire = strobe && (op == OP_STC);

    // R2: set-control always leaves control set; clear-control clears both
    a_r2_stc_sets_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_STC) |=> ctl);
    a_r2_clc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_CLC) |=> (!cmd && !ctl));
    // R3: hold/clear bit leaves flag clear when no word lands
    a_r3_hc_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hc && !word_in_valid) |=> !flg);
    // R9: a delivered word is stored, command drops, flag rises
    a_r9_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
        word_in_valid |=> (flg && !cmd && st_q.ibuf == $past(word_in)));
    // R10: arrival wins over a same-cycle hold/clear
    a_r10_arrival_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (word_in_valid && strobe && hc) |=> (flg && fbf));

endmodule

// File: rtl/ipl_tx_ser.sv
module ipl_tx_ser #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);

    localparam int BYTES = WORD_W / BYTE_W;
    localparam int CNT_W = (BYTES > 2) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            // A start while busy is dropped
            if (tx_ready) begin
                if (st_q.cnt == '0) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    st_d.sh  = st_q.sh << BYTE_W;
                end
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(BYTES - 1);
            st_d.sh   = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.busy;
    assign tx_data  = st_q.sh[WORD_W-1 -: BYTE_W];

    // R6: a stalled byte stays put
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R6: an idle start presents the upper byte next
    a_r6_upper_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && start) |=> (tx_valid && tx_data == $past(word[WORD_W-1 -: BYTE_W])));
    // R7: a start during a stalled word changes nothing
    a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && start && !tx_ready) |=> $stable(st_q.sh));

endmodule

// File: rtl/ipl_rx_asm.sv
module ipl_rx_asm #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);

    localparam int BYTES  = WORD_W / BYTE_W;
    localparam int CNT_W  = (BYTES > 2) ? $clog2(BYTES) : 1;
    localparam int HOLD_W = WORD_W - BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    logic              accept;
    logic [WORD_W-1:0] joined;

    assign accept = rx_valid && enable;
    assign joined = {st_q.hold, rx_data};

    always_comb begin
        st_d       = st_q;
        word_valid = 1'b0;
        word       = joined;
        if (accept) begin
            if (st_q.cnt == CNT_W'(BYTES - 1)) begin
                word_valid = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.hold = joined[HOLD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_ready = enable;

    // R9: a word is only produced while bytes are already held
    a_r9_needs_held_byte: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (st_q.cnt != '0));
    // R11: nothing is taken while disabled
    a_r11_blocked_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(st_q.cnt));

endmodule

// File: rtl/ipl_pair.sv
module ipl_pair
    import ipl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   diag_mode,
    input  logic [1:0]             io_strobe,
    input  logic [1:0][2:0]        io_op,
    input  logic [1:0]             io_hc,
    input  logic [1:0][WORD_W-1:0] io_wdata,
    output logic [1:0][WORD_W-1:0] io_rdata,
    output logic [1:0]             io_skip,
    output logic [1:0]             cmd_o,
    output logic [1:0]             ctl_o,
    output logic [1:0]             flag_o,
    output logic [1:0]             flagbuf_o,
    output logic [1:0]             tx_valid,
    output logic [1:0][BYTE_W-1:0] tx_data,
    input  logic [1:0]             tx_ready,
    input  logic [1:0]             rx_valid,
    input  logic [1:0][BYTE_W-1:0] rx_data,
    output logic [1:0]             rx_ready
);

    localparam int NCARD = 2;

    logic [NCARD-1:0]             stc_fire;
    logic [NCARD-1:0][WORD_W-1:0] obuf;
    logic [NCARD-1:0]             rx_wv;
    logic [NCARD-1:0][WORD_W-1:0] rx_word;
    logic [NCARD-1:0]             in_valid;
    logic [NCARD-1:0][WORD_W-1:0] in_word;

    for (genvar c = 0; c < NCARD; c++) begin : g_card
        localparam int P = NCARD - 1 - c;

        // Word into this card: from the partner (diagnostic) or the byte link
        assign in_valid[c] = rx_wv[c] || (diag_mode && stc_fire[P]);
        assign in_word[c]  = (diag_mode && stc_fire[P]) ? obuf[P] : rx_word[c];

        ipl_card_ctrl #(.WORD_W(WORD_W)) u_ctrl (
            .clk           (clk),
            .rst_n         (rst_n),
            .strobe        (io_strobe[c]),
            .op            (io_op_e'(io_op[c])),
            .hc            (io_hc[c]),
            .wdata         (io_wdata[c]),
            .rdata         (io_rdata[c]),
            .skip          (io_skip[c]),
            .word_in_valid (in_valid[c]),
            .word_in       (in_word[c]),
            .cmd           (cmd_o[c]),
            .ctl           (ctl_o[c]),
            .flg           (flag_o[c]),
            .fbf           (flagbuf_o[c]),
            .obuf          (obuf[c]),
            .stc_fire      (stc_fire[c])
        );

        ipl_tx_ser #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (stc_fire[c] && !diag_mode),
            .word     (obuf[c]),
            .tx_valid (tx_valid[c]),
            .tx_data  (tx_data[c]),
            .tx_ready (tx_ready[c])
        );

        ipl_rx_asm #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (!diag_mode),
            .rx_valid   (rx_valid[c]),
            .rx_data    (rx_data[c]),
            .rx_ready   (rx_ready[c]),
            .word_valid (rx_wv[c]),
            .word       (rx_word[c])
        );
    end

    // R8: a diagnostic set-control reaches the partner's flag
    a_r8_diag_partner_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode && stc_fire[0]) |=> flag_o[1]);

endmodule

// File: tb/ipl_pair_test.sv
`timescale 1ns/1ps
module ipl_pair_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             diag_mode = 1'b0;
    logic [1:0]       io_strobe = '0;
    logic [1:0][2:0]  io_op = '0;
    logic [1:0]       io_hc = '0;
    logic [1:0][15:0] io_wdata = '0;
    logic [1:0][15:0] io_rdata;
    logic [1:0]       io_skip, cmd_o, ctl_o, flag_o, flagbuf_o;
    logic [1:0]       tx_valid, tx_ready, rx_valid, rx_ready;
    logic [1:0][7:0]  tx_data, rx_data;

    logic             loop_en = 1'b0;
    logic [1:0]       b_rx_valid = '0;
    logic [1:0][7:0]  b_rx_data = '0;
    logic [1:0]       b_tx_ready = 2'b11;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    assign rx_valid = loop_en ? {tx_valid[0], tx_valid[1]} : b_rx_valid;
    assign rx_data  = loop_en ? {tx_data[0], tx_data[1]}   : b_rx_data;
    assign tx_ready = loop_en ? {rx_ready[0], rx_ready[1]} : b_tx_ready;

    ipl_pair uut (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode),
        .io_strobe(io_strobe), .io_op(io_op), .io_hc(io_hc),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_skip(io_skip),
        .cmd_o(cmd_o), .ctl_o(ctl_o), .flag_o(flag_o), .flagbuf_o(flagbuf_o),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    // {op[3], hc, wdata[16], exp rdata[16], exp skip, exp flag, exp cmd}
    localparam int NVEC = 14;
    localparam logic [38:0] VEC [NVEC] = '{
        {3'd4, 1'b0, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
        {3'd2, 1'b1, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b0},
        {3'd3, 1'b0, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0},
        {3'd4, 1'b0, 16'h0002, 16'h0002, 1'b0, 1'b0, 1'b0},
        {3'd2, 1'b0, 16'h0003, 16'h0003, 1'b0, 1'b1, 1'b0},
        {3'd5, 1'b0, 16'hA5C3, 16'hA5C3, 1'b0, 1'b1, 1'b0},
        {3'd6, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0},
        {3'd7, 1'b0, 16'h0F0F, 16'h0F0F, 1'b0, 1'b1, 1'b0},
        {3'd1, 1'b1, 16'h0004, 16'h0004, 1'b0, 1'b0, 1'b0},
        {3'd0, 1'b0, 16'h0005, 16'h0005, 1'b0, 1'b0, 1'b1},
        {3'd4, 1'b0, 16'h0006, 16'h0006, 1'b0, 1'b0, 1'b1},
        {3'd2, 1'b1, 16'h0007, 16'h0007, 1'b0, 1'b0, 1'b1},
        {3'd1, 1'b0, 16'h0008, 16'h0008, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input int c, input logic [2:0] op, input logic hc,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output logic sk);
        io_strobe[c] = 1'b1;
        io_op[c]     = op;
        io_hc[c]     = hc;
        io_wdata[c]  = wd;
        #1;
        rd = io_rdata[c];
        sk = io_skip[c];
        @(negedge clk);
        io_strobe = '0;
        io_hc     = '0;
    endtask

    task automatic op1(input int c, input logic [2:0] op, input logic hc,
                       input logic [15:0] wd);
        logic [15:0] rd;
        logic        sk;
        do_op(c, op, hc, wd, rd, sk);
    endtask

    task automatic load(input int c, output logic [15:0] rd);
        logic sk;
        do_op(c, 3'd6, 1'b0, 16'h0000, rd, sk);
    endtask

    task automatic send_byte(input int c, input logic [7:0] b);
        b_rx_valid[c] = 1'b1;
        b_rx_data[c]  = b;
        @(negedge clk);
        b_rx_valid = '0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] rd;
        logic        sk;
        @(negedge clk);
        apply_reset();

        // R1: reset state
        check("R1", "cmd", cmd_o, 2'b00);
        check("R1", "ctl", ctl_o, 2'b00);
        check("R1", "flag", flag_o, 2'b11);
        check("R1", "flagbuf", flagbuf_o, 2'b11);
        check("R1", "tx_valid", tx_valid, 2'b00);
        check("R11", "rx_ready link", rx_ready, 2'b11);
        load(1, rd);
        check("R1", "load after reset", rd, 16'h0000);

        // Vector table on card 0 (R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            do_op(0, VEC[i][38:36], VEC[i][35], VEC[i][34:19], rd, sk);
            check("R5", $sformatf("vec %0d rdata", i), rd, VEC[i][18:3]);
            check("R4", $sformatf("vec %0d skip", i), sk, VEC[i][2]);
            check("R3", $sformatf("vec %0d flag", i), flag_o[0], VEC[i][1]);
            check("R2", $sformatf("vec %0d cmd", i), cmd_o[0], VEC[i][0]);
        end

        // R2: control follows set/clear-control
        op1(1, 3'd0, 1'b0, 16'h0);
        check("R2", "ctl after set-control", ctl_o[1], 1'b1);
        op1(1, 3'd1, 1'b0, 16'h0);
        check("R2", "ctl after clear-control", ctl_o[1], 1'b0);
        repeat (3) @(negedge clk);

        // R6/R7: byte order, stall hold, busy drop
        b_tx_ready[0] = 1'b0;
        op1(0, 3'd5, 1'b0, 16'hBEEF);
        op1(0, 3'd0, 1'b0, 16'h0);
        check("R6", "tx_valid after start", tx_valid[0], 1'b1);
        check("R6", "upper byte first", tx_data[0], 8'hBE);
        repeat (2) @(negedge clk);
        check("R6", "stall keeps byte", tx_data[0], 8'hBE);
        op1(0, 3'd5, 1'b0, 16'h1111);
        op1(0, 3'd0, 1'b0, 16'h0);
        check("R7", "busy start keeps byte", tx_data[0], 8'hBE);
        b_tx_ready[0] = 1'b1;
        @(negedge clk);
        check("R6", "lower byte second valid", tx_valid[0], 1'b1);
        check("R6", "lower byte second", tx_data[0], 8'hEF);
        @(negedge clk);
        check("R6", "valid drops after word", tx_valid[0], 1'b0);
        @(negedge clk);
        check("R7", "dropped start sends nothing", tx_valid[0], 1'b0);

        // R9: byte reassembly
        op1(0, 3'd0, 1'b1, 16'h0);
        send_byte(0, 8'h12);
        check("R9", "first byte no flag", flag_o[0], 1'b0);
        check("R9", "first byte cmd kept", cmd_o[0], 1'b1);
        repeat (3) @(negedge clk);
        send_byte(0, 8'h34);
        check("R9", "word flag", flag_o[0], 1'b1);
        check("R9", "word clears cmd", cmd_o[0], 1'b0);
        load(0, rd);
        check("R9", "word value", rd, 16'h1234);

        // R1: reset discards a held byte
        send_byte(0, 8'h77);
        apply_reset();
        op1(0, 3'd3, 1'b1, 16'h0);
        send_byte(0, 8'h99);
        check("R1", "held byte discarded by reset", flag_o[0], 1'b0);
        send_byte(0, 8'hAA);
        load(0, rd);
        check("R1", "word after reset", rd, 16'h99AA);

        // R10: completion and set-control with hold/clear in the same cycle
        op1(0, 3'd0, 1'b1, 16'h0);
        repeat (3) @(negedge clk);
        send_byte(0, 8'h56);
        b_rx_valid[0] = 1'b1;
        b_rx_data[0]  = 8'h78;
        io_strobe[0]  = 1'b1;
        io_op[0]      = 3'd0;
        io_hc[0]      = 1'b1;
        @(negedge clk);
        b_rx_valid = '0;
        io_strobe  = '0;
        io_hc      = '0;
        check("R10", "flag wins", flag_o[0], 1'b1);
        check("R10", "cmd cleared", cmd_o[0], 1'b0);
        check("R10", "ctl set", ctl_o[0], 1'b1);
        load(0, rd);
        check("R10", "word stored", rd, 16'h5678);
        repeat (3) @(negedge clk);

        // R8/R11/R12: diagnostic cross-wiring both ways
        diag_mode = 1'b1;
        @(negedge clk);
        check("R11", "rx_ready diag", rx_ready, 2'b00);
        op1(0, 3'd5, 1'b0, 16'hC0DE);
        op1(1, 3'd3, 1'b1, 16'h0);
        check("R8", "partner flag cleared first", flag_o[1], 1'b0);
        op1(0, 3'd0, 1'b0, 16'h0);
        check("R8", "partner flag set", flag_o[1], 1'b1);
        check("R8", "no byte sent", tx_valid[0], 1'b0);
        load(1, rd);
        check("R8", "partner input", rd, 16'hC0DE);
        op1(1, 3'd5, 1'b0, 16'h5A5A);
        op1(0, 3'd3, 1'b1, 16'h0);
        op1(1, 3'd0, 1'b0, 16'h0);
        check("R12", "reverse flag", flag_o[0], 1'b1);
        load(0, rd);
        check("R12", "reverse input", rd, 16'h5A5A);
        op1(1, 3'd3, 1'b1, 16'h0);
        send_byte(1, 8'h11);
        send_byte(1, 8'h22);
        check("R11", "diag bytes ignored flag", flag_o[1], 1'b0);
        load(1, rd);
        check("R11", "diag bytes ignored data", rd, 16'hC0DE);
        diag_mode = 1'b0;
        @(negedge clk);
        check("R11", "rx_ready back", rx_ready, 2'b11);
        send_byte(1, 8'h33);
        send_byte(1, 8'h44);
        load(1, rd);
        check("R11", "nothing held from diag", rd, 16'h3344);

        // R12/R6/R9: card-to-card link exchange
        loop_en = 1'b1;
        op1(0, 3'd5, 1'b0, 16'h9E37);
        op1(1, 3'd3, 1'b1, 16'h0);
        op1(0, 3'd0, 1'b0, 16'h0);
        for (int k = 0; k < 10 && !flag_o[1]; k++) @(negedge clk);
        check("R12", "link flag card1", flag_o[1], 1'b1);
        load(1, rd);
        check("R12", "link word card1", rd, 16'h9E37);
        op1(1, 3'd5, 1'b0, 16'h0FF1);
        op1(0, 3'd3, 1'b1, 16'h0);
        op1(1, 3'd0, 1'b0, 16'h0);
        for (int k = 0; k < 10 && !flag_o[0]; k++) @(negedge clk);
        check("R12", "link flag card0", flag_o[0], 1'b1);
        load(0, rd);
        check("R9", "link word card0", rd, 16'h0FF1);
        loop_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule